// File: doc/BRIEF.md
# Single-Step Non-Restoring Divider

This block carries out one iteration of a non-restoring binary division each time it is strobed. It keeps three status bits between steps: a quotient-tracking bit Q, a divisor-sign bit M and a result bit T. T plays two parts. It supplies the bit shifted into the low end of the partial remainder, and it also holds the quotient bit that the step produces. A sequencer or software loop calls the step once for each quotient bit and collects each T into the quotient. Correcting the quotient for signed operands, before or after the loop, is left to that caller.

A separate initialise command prepares Q, M and T for a division. For signed operation it derives them from the signs of the divisor and the dividend. For unsigned operation it clears all three. Each step takes one clock. The new partial remainder and status bits come from registers, and a one-cycle done pulse marks the result.

Top module: `divstep_unit`

## Requirements
- R1: While synchronous reset is high, Q, M, T, done_o and rem_o are all cleared to zero on each clock edge.
- R2: An unsigned initialise (init_i=1, init_signed_i=0) clears Q, M and T on the next edge.
- R3: A signed initialise (init_i=1, init_signed_i=1) sets M to divisor_i bit 31 and sets both Q and T to divisor_i bit 31 XOR rem_i bit 31 (rem_i carries the dividend).
- R4: A step shifts rem_i left by one place and puts the current T into the new bit 0. The bit shifted out of bit 31 is the step's msb.
- R5: A step subtracts divisor_i from the shifted remainder when the old Q equals M, and adds it otherwise. rem_o takes the 32-bit result.
- R6: After a step, Q equals msb XOR cb XOR M. Here cb is the unsigned carry out of bit 31 for an add, or the borrow for a subtract.
- R7: After a step, T is 1 exactly when the new Q equals M, and M is left unchanged.
- R8: done_o is high for exactly one cycle, in the cycle after a step is accepted, and is low at all other times.
- R9: When init_i and step_i are high together, the initialise takes effect and the step is dropped: rem_o keeps its value and done_o stays low.
- R10: In a cycle with neither init_i nor step_i, rem_o, Q, M and T keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Initialise command for Q, M and T |
| init_signed_i | input | 1 | Selects signed (1) or unsigned (0) initialise |
| step_i | input | 1 | Start one division step |
| divisor_i | input | 32 | Divisor word |
| rem_i | input | 32 | Partial remainder for a step; dividend sign source for an initialise |
| rem_o | output | 32 | Registered updated partial remainder |
| q_o | output | 1 | Q status bit |
| m_o | output | 1 | M status bit |
| t_o | output | 1 | T status bit (quotient bit of the last step) |
| done_o | output | 1 | One-cycle pulse after each accepted step |

## Verification
The properties assume that init_i, init_signed_i and step_i are driven to known levels on every clock edge once reset has been sampled. They also assume that a step is judged only by the registered outputs in the following cycle, so that no command is still in flight. The bench changes inputs only on the falling clock edge and holds every control strobe at a defined 0 or 1 from time zero. It brings each command back to idle after exactly one edge, except where an idle cycle or a simultaneous init-and-step is the case under test.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
   localparam int unsigned DS_WIDTH = 32;

   typedef enum logic [1:0] {
      DS_IDLE = 2'd0,
      DS_INIT = 2'd1,
      DS_STEP = 2'd2
   } ds_cmd_e;

   typedef struct packed {
      logic q;
      logic m;
      logic t;
   } ds_flags_t;
endpackage

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          ONE_ADDER  = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cb_o
);
   localparam int unsigned XW = WIDTH + 1;

   generate
      if (ONE_ADDER) begin : g_shared
         logic [XW-1:0] ext;
         logic [WIDTH-1:0] b_inv;
         always_comb begin
            b_inv = b_i ^ {WIDTH{sub_i}};
            ext   = {1'b0, a_i} + {1'b0, b_inv} + {{(XW-1){1'b0}}, sub_i};
            sum_o = ext[WIDTH-1:0];
            // for subtract, carry out of a + ~b + 1 is the inverse of borrow
            cb_o  = ext[XW-1] ^ sub_i;
         end
      end else begin : g_split
         logic [XW-1:0] ext_add;
         logic [XW-1:0] ext_sub;
         always_comb begin
            ext_add = {1'b0, a_i} + {1'b0, b_i};
            ext_sub = {1'b0, a_i} - {1'b0, b_i};
            sum_o   = sub_i ? ext_sub[WIDTH-1:0] : ext_add[WIDTH-1:0];
            cb_o    = sub_i ? ext_sub[XW-1]      : ext_add[XW-1];
         end
      end
   endgenerate
endmodule

// File: rtl/divstep_qlogic.sv
module divstep_qlogic (
   input  logic msb_i,
   input  logic cb_i,
   input  logic m_i,
   output logic q_nx_o,
   output logic t_nx_o
);
   always_comb begin
      q_nx_o = msb_i ^ cb_i ^ m_i;
      t_nx_o = ~(q_nx_o ^ m_i);
   end
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit #(
   parameter int unsigned WIDTH     = divstep_pkg::DS_WIDTH,
   parameter bit          ONE_ADDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             init_i,
   input  logic             init_signed_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] divisor_i,
   input  logic [WIDTH-1:0] rem_i,
   output logic [WIDTH-1:0] rem_o,
   output logic             q_o,
   output logic             m_o,
   output logic             t_o,
   output logic             done_o
);
   import divstep_pkg::*;

   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("divstep_unit: WIDTH must be at least 2");
      end
   endgenerate

   ds_flags_t        flags_q;
   ds_cmd_e          cmd;
   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] sum;
   logic             cb;
   logic             do_sub;
   logic             q_nx;
   logic             t_nx;
   logic             sign_x;
   logic [WIDTH-1:0] rem_q;
   logic             done_q;

   always_comb begin
      if (init_i)      cmd = DS_INIT;
      else if (step_i) cmd = DS_STEP;
      else             cmd = DS_IDLE;
      shifted = {rem_i[MSB-1:0], flags_q.t};
      do_sub  = (flags_q.q == flags_q.m);
      sign_x  = divisor_i[MSB] ^ rem_i[MSB];
   end

   divstep_addsub #(
      .WIDTH     (WIDTH),
      .ONE_ADDER (ONE_ADDER)
   ) u_addsub (
      .a_i   (shifted),
      .b_i   (divisor_i),
      .sub_i (do_sub),
      .sum_o (sum),
      .cb_o  (cb)
   );

   divstep_qlogic u_qlogic (
      .msb_i  (rem_i[MSB]),
      .cb_i   (cb),
      .m_i    (flags_q.m),
      .q_nx_o (q_nx),
      .t_nx_o (t_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
         rem_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (cmd)
            DS_INIT: begin
               if (init_signed_i) begin
                  flags_q.q <= sign_x;
                  flags_q.m <= divisor_i[MSB];
                  flags_q.t <= sign_x;
               end else begin
                  flags_q <= '0;
               end
            end
            DS_STEP: begin
               rem_q     <= sum;
               flags_q.q <= q_nx;
               flags_q.t <= t_nx;
               done_q    <= 1'b1;
            end
            default: begin
            end
         endcase
      end
   end

   assign rem_o  = rem_q;
   assign q_o    = flags_q.q;
   assign m_o    = flags_q.m;
   assign t_o    = flags_q.t;
   assign done_o = done_q;
endmodule

// File: rtl/divstep_unit_chk.sv
module divstep_unit_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             init_i,
   input logic             init_signed_i,
   input logic             step_i,
   input logic [WIDTH-1:0] divisor_i,
   input logic [WIDTH-1:0] rem_i,
   input logic [WIDTH-1:0] rem_o,
   input logic             q_o,
   input logic             m_o,
   input logic             t_o,
   input logic             done_o
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!q_o && !m_o && !t_o && !done_o && rem_o == '0));

   assert_unsigned_init_R2: assert property (@(posedge clk) disable iff (rst)
      (init_i && !init_signed_i) |=> (!q_o && !m_o && !t_o));

   assert_signed_init_R3: assert property (@(posedge clk) disable iff (rst)
      (init_i && init_signed_i) |=>
         (m_o == $past(divisor_i[WIDTH-1]) && q_o == t_o &&
          q_o == ($past(divisor_i[WIDTH-1]) ^ $past(rem_i[WIDTH-1]))));

   assert_t_tracks_q_R7: assert property (@(posedge clk) disable iff (rst)
      (step_i && !init_i) |=> (t_o == (q_o == m_o) && $stable(m_o)));

   assert_done_after_step_R8: assert property (@(posedge clk) disable iff (rst)
      (step_i && !init_i) |=> done_o);

   assert_no_spurious_done_R8: assert property (@(posedge clk) disable iff (rst)
      !(step_i && !init_i) |=> !done_o);

   assert_init_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (init_i && step_i) |=> $stable(rem_o));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!init_i && !step_i) |=>
         ($stable(rem_o) && $stable(q_o) && $stable(m_o) && $stable(t_o)));
endmodule

bind divstep_unit divstep_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .init_i        (init_i),
   .init_signed_i (init_signed_i),
   .step_i        (step_i),
   .divisor_i     (divisor_i),
   .rem_i         (rem_i),
   .rem_o         (rem_o),
   .q_o           (q_o),
   .m_o           (m_o),
   .t_o           (t_o),
   .done_o        (done_o)
);

// File: tb/divstep_unit_tb.sv
module divstep_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        init_i = 1'b0;
   logic        init_signed_i = 1'b0;
   logic        step_i = 1'b0;
   logic [31:0] divisor_i = '0;
   logic [31:0] rem_i = '0;
   logic [31:0] rem_o;
   logic        q_o, m_o, t_o, done_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   // reference state built from the requirements
   logic        mq, mm, mt;
   logic [31:0] mrem;

   always #2 clk = ~clk;

   divstep_unit u_dut (
      .clk(clk), .rst(rst), .init_i(init_i), .init_signed_i(init_signed_i),
      .step_i(step_i), .divisor_i(divisor_i), .rem_i(rem_i),
      .rem_o(rem_o), .q_o(q_o), .m_o(m_o), .t_o(t_o), .done_o(done_o)
   );

   typedef struct packed {
      logic        sgn;
      logic [31:0] idiv;
      logic [31:0] irem;
      logic [31:0] sdiv;
      logic [31:0] srem;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0003, 32'h8000_0001},
      '{1'b0, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF},
      '{1'b1, 32'h8000_0000, 32'h0000_0010, 32'hFFFF_FFF9, 32'h0000_1234},
      '{1'b1, 32'h8000_0007, 32'h8000_0000, 32'hFFFF_FFF9, 32'hFFFF_0000},
      '{1'b1, 32'h0000_0007, 32'h8000_0000, 32'h0000_0007, 32'hF000_0001},
      '{1'b1, 32'h0000_0005, 32'h0000_0009, 32'h0000_0005, 32'h4000_0000},
      '{1'b1, 32'hC000_0000, 32'hC000_0000, 32'h4000_0000, 32'hC000_0000},
      '{1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF}
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " rem"}, rem_o, mrem);
      check({tag, " Q"}, {31'd0, q_o}, {31'd0, mq});
      check({tag, " M"}, {31'd0, m_o}, {31'd0, mm});
      check({tag, " T"}, {31'd0, t_o}, {31'd0, mt});
   endtask

   task automatic model_init(input logic sgn, input logic [31:0] d, input logic [31:0] r);
      if (sgn) begin
         mq = d[31] ^ r[31];
         mm = d[31];
         mt = d[31] ^ r[31];
      end else begin
         mq = 1'b0; mm = 1'b0; mt = 1'b0;
      end
   endtask

   task automatic model_step(input logic [31:0] d, input logic [31:0] r);
      logic [31:0] sh;
      logic [32:0] full;
      sh = {r[30:0], mt};
      if (mq == mm) full = {1'b0, sh} - {1'b0, d};
      else          full = {1'b0, sh} + {1'b0, d};
      mq   = r[31] ^ full[32] ^ mm;
      mt   = (mq == mm);
      mrem = full[31:0];
   endtask

   task automatic do_init(input logic sgn, input logic [31:0] d, input logic [31:0] r);
      init_i = 1'b1; init_signed_i = sgn; divisor_i = d; rem_i = r;
      @(negedge clk);
      init_i = 1'b0;
      model_init(sgn, d, r);
   endtask

   task automatic do_step(input logic [31:0] d, input logic [31:0] r);
      step_i = 1'b1; divisor_i = d; rem_i = r;
      @(negedge clk);
      step_i = 1'b0;
      model_step(d, r);
   endtask

   initial begin
      #(4 * 150000);
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      mq = 0; mm = 0; mt = 0; mrem = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check_all("R1 reset");
      check("R1 done", {31'd0, done_o}, 32'd0);

      // vector walk: initialise then two chained steps (R3/R2, R4..R7)
      for (int i = 0; i < 8; i++) begin
         do_init(VEC[i].sgn, VEC[i].idiv, VEC[i].irem);
         check_all(VEC[i].sgn ? "R3 init" : "R2 init");
         do_step(VEC[i].sdiv, VEC[i].srem);
         check_all("R5 R6 R7 step1");
         check("R8 done", {31'd0, done_o}, 32'd1);
         do_step(VEC[i].sdiv, rem_o);
         check_all("R4 step2");
      end

      // hand-worked corners: unsigned, 0x80000001 / 3 -> borrow
      do_init(1'b0, 32'h0, 32'h0);
      do_step(32'h0000_0003, 32'h8000_0001);
      check("R5 borrow rem", rem_o, 32'hFFFF_FFFF);
      check("R6 borrow Q", {31'd0, q_o}, 32'd0);
      check("R7 borrow T", {31'd0, t_o}, 32'd1);
      // R4: T=1 feeds bit 0: sh=0x3, minus 1 -> 0x2, no borrow, msb 0
      do_step(32'h0000_0001, 32'h0000_0001);
      check("R4 T shifted in", rem_o, 32'h0000_0002);
      check("R6 no borrow Q", {31'd0, q_o}, 32'd0);

      // R8 / R10: idle cycle keeps values and drops done
      @(negedge clk);
      check("R8 done one cycle", {31'd0, done_o}, 32'd0);
      check_all("R10 idle");
      rem_i = 32'hDEAD_BEEF; divisor_i = 32'h1234_5678;
      @(negedge clk);
      check_all("R10 inputs ignored");

      // R9: init and step together: init wins
      init_i = 1'b1; init_signed_i = 1'b1; step_i = 1'b1;
      divisor_i = 32'h8000_0000; rem_i = 32'h0000_0001;
      @(negedge clk);
      init_i = 1'b0; step_i = 1'b0;
      model_init(1'b1, 32'h8000_0000, 32'h0000_0001);
      check_all("R9 init priority");
      check("R9 no done", {31'd0, done_o}, 32'd0);

      // R1: reset mid-operation
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      mq = 0; mm = 0; mt = 0; mrem = '0;
      check_all("R1 re-reset");

      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule